// File: doc/BRIEF.md
# RV32I Integer Execute Unit

This block is the combinational integer datapath of an RV32I core. It takes a 32-bit instruction word, the two register operand values read for that instruction and the program counter of that instruction. From these it produces the value to be written back, a write-enable flag for the register file and a flag that marks the word as an encoding this unit does not accept.

The unit covers the register-register and register-immediate arithmetic, logic, shift and compare groups, plus the two upper-immediate forms: load-upper and add-upper-to-PC. It decodes the opcode, the three-bit function field and the seven-bit function field directly. For immediate shifts the upper immediate bits are treated as the seven-bit function field. Loads, stores, control transfer, system instructions and multiply are handled elsewhere, so this unit rejects them.

The surrounding pipeline places its own registers around the unit. The unit has no state, no clock and no reset.

Top module: `rv_int_exec`

## Requirements
- R1: With opcode 0110011 and seven-bit function field (bits [31:25]) equal to 0000000, function field bits [14:12] select the result: 000 sum, 100 xor, 110 or, 111 and. With bits [31:25] = 0100000 and bits [14:12] = 000, the result is rs1 minus rs2.
- R2: With opcode 0110011, bits [14:12] = 001 shifts rs1 left, and 101 shifts rs1 right. The right shift fills with zeros when bits [31:25] = 0000000 and with the sign bit when they are 0100000. Only rs2[4:0] is used as the shift amount.
- R3: Bits [14:12] = 010 give 1 when the first operand is less than the second as signed values and 0 otherwise. Bits [14:12] = 011 do the same compare as unsigned values. This holds for opcode 0110011 (second operand rs2) and for opcode 0010011 (second operand the immediate).
- R4: With opcode 0010011, the immediate is bits [31:20] sign-extended to 32 bits. Bits [14:12] = 000 add it to rs1, 100 xor it, 110 or it and 111 and it. Bits [31:25] do not matter for these codes.
- R5: With opcode 0010011 and bits [14:12] = 011, the immediate is sign-extended first and then compared with rs1 as unsigned.
- R6: With opcode 0010011, bits [14:12] = 001 or 101 shift rs1 by bits [24:20]. Code 001 needs bits [31:25] = 0000000. Code 101 shifts with zero fill for 0000000 and with sign fill for 0100000.
- R7: Opcode 0110111 gives bits [31:12] of the instruction followed by twelve zero bits.
- R8: Opcode 0010111 gives the PC input plus bits [31:12] of the instruction followed by twelve zero bits, wrapping modulo 2^32.
- R9: The illegal flag is 1, write-enable is 0 and the result is 0 in these cases: any opcode other than the four above; opcode 0110011 with bits [31:25] other than 0000000, or other than 0100000 together with bits [14:12] = 000 or 101; opcode 0010011 with code 001 and bits [31:25] not 0000000; opcode 0010011 with code 101 and bits [31:25] neither 0000000 nor 0100000.
- R10: For an accepted word, write-enable is 1 when the destination field (bits [11:7]) is non-zero and 0 when it is zero. The result value does not depend on the destination field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| rs1_val_i | input | 32 | Value of the first source register |
| rs2_val_i | input | 32 | Value of the second source register |
| pc_i | input | 32 | Address of the instruction, used by add-upper-to-PC |
| result_o | output | 32 | Value to write back; zero for a rejected word |
| wr_en_o | output | 1 | Register write request |
| illegal_o | output | 1 | Instruction word not accepted by this unit |

## Verification
Register-register words are swept over all eight function codes and all 128 seven-bit function values. Operands are taken from a set that includes zero, one, all ones, the most negative and most positive values, and a pattern with bits set above bit 4. This separates signed from unsigned compare and add from subtract, and it shows that shift amounts are taken modulo 32. Immediate words are run with immediates that have the sign bit clear and set, which separates the sign-extended unsigned compare from a zero-extended one. Immediate shifts are swept over every shift amount and every upper-field value, which separates zero fill, sign fill and rejection. A sweep of all 128 opcodes and of all 32 destination indices checks the rejection and write-enable rules.

// File: rtl/rv_int_exec_pkg.sv
package rv_int_exec_pkg;

    localparam int XLEN    = 32;
    localparam int SHAMT_W = $clog2(XLEN);
    localparam int OPC_W   = 7;
    localparam int F3_W    = 3;
    localparam int F7_W    = 7;
    localparam int REG_W   = 5;
    localparam int IMMI_W  = 12;
    localparam int IMMU_W  = 20;

    localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LUI   = 7'b0110111;
    localparam logic [OPC_W-1:0] OPC_AUIPC = 7'b0010111;

    localparam logic [F7_W-1:0] F7_BASE = 7'b0000000;
    localparam logic [F7_W-1:0] F7_ALT  = 7'b0100000;

    localparam logic [F3_W-1:0] F3_ADD  = 3'b000;
    localparam logic [F3_W-1:0] F3_SLL  = 3'b001;
    localparam logic [F3_W-1:0] F3_SLT  = 3'b010;
    localparam logic [F3_W-1:0] F3_SLTU = 3'b011;
    localparam logic [F3_W-1:0] F3_XOR  = 3'b100;
    localparam logic [F3_W-1:0] F3_SR   = 3'b101;
    localparam logic [F3_W-1:0] F3_OR   = 3'b110;
    localparam logic [F3_W-1:0] F3_AND  = 3'b111;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
    } alu_op_e;

    typedef enum logic [1:0] {SRC_A_RS1, SRC_A_PC, SRC_A_ZERO} src_a_e;
    typedef enum logic [1:0] {SRC_B_RS2, SRC_B_IMMI, SRC_B_IMMU} src_b_e;

    typedef struct packed {
        alu_op_e op;
        src_a_e  src_a;
        src_b_e  src_b;
        logic    legal;
    } exec_ctrl_t;

    typedef struct packed {
        logic [F7_W-1:0]  f7;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rs1;
        logic [F3_W-1:0]  f3;
        logic [REG_W-1:0] rd;
        logic [OPC_W-1:0] opc;
    } instr_fields_t;

    // Map a three-bit function code plus the alternate-form bit to an ALU op.
    function automatic alu_op_e f3_to_op(input logic [F3_W-1:0] f3, input logic alt);
        alu_op_e op;
        case (f3)
            F3_ADD:  op = alt ? ALU_SUB : ALU_ADD;
            F3_SLL:  op = ALU_SLL;
            F3_SLT:  op = ALU_SLT;
            F3_SLTU: op = ALU_SLTU;
            F3_XOR:  op = ALU_XOR;
            F3_SR:   op = alt ? ALU_SRA : ALU_SRL;
            F3_OR:   op = ALU_OR;
            default: op = ALU_AND;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rv_int_exec_decode.sv
module rv_int_exec_decode
    import rv_int_exec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output exec_ctrl_t      ctrl,
    output logic            rd_nonzero
);

    instr_fields_t fld;
    assign fld        = instr_fields_t'(instr);
    assign rd_nonzero = |fld.rd;

    always_comb begin
        ctrl.op    = ALU_ADD;
        ctrl.src_a = SRC_A_ZERO;
        ctrl.src_b = SRC_B_RS2;
        ctrl.legal = 1'b0;
        case (fld.opc)
            OPC_REG: begin
                ctrl.src_a = SRC_A_RS1;
                ctrl.src_b = SRC_B_RS2;
                if (fld.f7 == F7_BASE) begin
                    ctrl.legal = 1'b1;
                    ctrl.op    = f3_to_op(fld.f3, 1'b0);
                end else if (fld.f7 == F7_ALT &&
                             (fld.f3 == F3_ADD || fld.f3 == F3_SR)) begin
                    ctrl.legal = 1'b1;
                    ctrl.op    = f3_to_op(fld.f3, 1'b1);
                end
            end
            OPC_IMM: begin
                ctrl.src_a = SRC_A_RS1;
                ctrl.src_b = SRC_B_IMMI;
                case (fld.f3)
                    F3_SLL: begin
                        ctrl.legal = (fld.f7 == F7_BASE);
                        ctrl.op    = ALU_SLL;
                    end
                    F3_SR: begin
                        ctrl.legal = (fld.f7 == F7_BASE) || (fld.f7 == F7_ALT);
                        ctrl.op    = f3_to_op(fld.f3, fld.f7 == F7_ALT);
                    end
                    default: begin
                        ctrl.legal = 1'b1;
                        ctrl.op    = f3_to_op(fld.f3, 1'b0);
                    end
                endcase
            end
            OPC_LUI: begin
                ctrl.legal = 1'b1;
                ctrl.src_a = SRC_A_ZERO;
                ctrl.src_b = SRC_B_IMMU;
            end
            OPC_AUIPC: begin
                ctrl.legal = 1'b1;
                ctrl.src_a = SRC_A_PC;
                ctrl.src_b = SRC_B_IMMU;
            end
            default: ctrl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/rv_int_exec_operands.sv
module rv_int_exec_operands
    import rv_int_exec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [XLEN-1:0] pc,
    input  src_a_e          src_a,
    input  src_b_e          src_b,
    output logic [XLEN-1:0] op_a,
    output logic [XLEN-1:0] op_b
);

    localparam int IMMI_LSB = XLEN - IMMI_W;
    localparam int IMMU_LSB = XLEN - IMMU_W;

    logic [XLEN-1:0] imm_i;
    logic [XLEN-1:0] imm_u;

    assign imm_i = {{(XLEN-IMMI_W){instr[XLEN-1]}}, instr[XLEN-1:IMMI_LSB]};
    assign imm_u = {instr[XLEN-1:IMMU_LSB], {IMMU_LSB{1'b0}}};

    always_comb begin
        case (src_a)
            SRC_A_RS1: op_a = rs1_val;
            SRC_A_PC:  op_a = pc;
            default:   op_a = '0;
        endcase
        case (src_b)
            SRC_B_IMMI: op_b = imm_i;
            SRC_B_IMMU: op_b = imm_u;
            default:    op_b = rs2_val;
        endcase
    end

endmodule

// File: rtl/rv_int_exec_alu.sv
module rv_int_exec_alu
    import rv_int_exec_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    logic [SHAMT_W-1:0] shamt;
    logic               lt_s;
    logic               lt_u;

    assign shamt = b[SHAMT_W-1:0];
    assign lt_s  = $signed(a) < $signed(b);
    assign lt_u  = a < b;

    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << shamt;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, lt_s};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, lt_u};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = XLEN'($signed(a) >>> shamt);
            ALU_OR:   y = a | b;
            default:  y = a & b;
        endcase
    end

endmodule

// File: rtl/rv_int_exec.sv
module rv_int_exec
    import rv_int_exec_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] rs1_val_i,
    input  logic [31:0] rs2_val_i,
    input  logic [31:0] pc_i,
    output logic [31:0] result_o,
    output logic        wr_en_o,
    output logic        illegal_o
);

    exec_ctrl_t      ctrl;
    logic            rd_nonzero;
    logic [XLEN-1:0] op_a;
    logic [XLEN-1:0] op_b;
    logic [XLEN-1:0] alu_y;

    rv_int_exec_decode i_decode (
        .instr      (instr_i),
        .ctrl       (ctrl),
        .rd_nonzero (rd_nonzero)
    );

    rv_int_exec_operands i_operands (
        .instr   (instr_i),
        .rs1_val (rs1_val_i),
        .rs2_val (rs2_val_i),
        .pc      (pc_i),
        .src_a   (ctrl.src_a),
        .src_b   (ctrl.src_b),
        .op_a    (op_a),
        .op_b    (op_b)
    );

    rv_int_exec_alu i_alu (
        .op (ctrl.op),
        .a  (op_a),
        .b  (op_b),
        .y  (alu_y)
    );

    assign result_o  = ctrl.legal ? alu_y : '0;
    assign wr_en_o   = ctrl.legal & rd_nonzero;
    assign illegal_o = ~ctrl.legal;

endmodule

// File: rtl/rv_int_exec_chk.sv
module rv_int_exec_chk (
    input logic [31:0] instr_i,
    input logic [31:0] result_o,
    input logic        wr_en_o,
    input logic        illegal_o
);

    logic [6:0] opc;
    logic [2:0] f3;
    assign opc = instr_i[6:0];
    assign f3  = instr_i[14:12];

    always_comb begin
        if (!$isunknown(instr_i)) begin
            // R9
            illegal_no_write_chk: assert (!(illegal_o && wr_en_o))
                else $error("write requested for rejected word");
            // R9
            illegal_zero_result_chk: assert (!illegal_o || result_o == 32'h0)
                else $error("rejected word produced a non-zero result");
            // R10
            x0_no_write_chk: assert (instr_i[11:7] != 5'd0 || !wr_en_o)
                else $error("write requested to register zero");
            // R3
            compare_is_bit_chk: assert (illegal_o ||
                    !((opc == 7'b0110011 || opc == 7'b0010011) &&
                      (f3 == 3'b010 || f3 == 3'b011)) ||
                    result_o[31:1] == 31'h0)
                else $error("compare result wider than one bit");
            // R7
            upper_low_zero_chk: assert (opc != 7'b0110111 || result_o[11:0] == 12'h0)
                else $error("load-upper result has non-zero low bits");
            // R9
            unknown_opc_chk: assert (opc == 7'b0110011 || opc == 7'b0010011 ||
                    opc == 7'b0110111 || opc == 7'b0010111 || illegal_o)
                else $error("unsupported opcode accepted");
        end
    end

endmodule

bind rv_int_exec rv_int_exec_chk i_rv_int_exec_chk (
    .instr_i   (instr_i),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .illegal_o (illegal_o)
);

// File: tb/test_rv_int_exec.sv
`timescale 1ns/1ps
module test_rv_int_exec;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs1 = 32'h0;
    logic [31:0] rs2 = 32'h0;
    logic [31:0] pc = 32'h0;
    logic [31:0] result;
    logic        wr_en;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rv_int_exec i_rv_int_exec (
        .instr_i   (instr),
        .rs1_val_i (rs1),
        .rs2_val_i (rs2),
        .pc_i      (pc),
        .result_o  (result),
        .wr_en_o   (wr_en),
        .illegal_o (illegal)
    );

    logic [31:0] pats [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h0000_001F, 32'h1234_5678, 32'hFFFF_FFE3};

    // Expected behaviour written from the requirements.
    function automatic void model(input logic [31:0] ins, input logic [31:0] a,
                                  input logic [31:0] b, input logic [31:0] p,
                                  output logic [31:0] r, output logic we,
                                  output logic ill, output string tag);
        logic [6:0]  opc = ins[6:0];
        logic [2:0]  f3  = ins[14:12];
        logic [6:0]  f7  = ins[31:25];
        logic [31:0] immi = {{20{ins[31]}}, ins[31:20]};
        logic [31:0] immu = {ins[31:12], 12'h0};
        logic [31:0] y;
        logic        alt;
        r = 32'h0; ill = 1'b1; tag = "R9";
        if (opc == 7'b0110011 || opc == 7'b0010011) begin
            if (opc == 7'b0110011) begin
                y   = b;
                ill = !(f7 == 7'h00 || (f7 == 7'h20 && (f3 == 3'd0 || f3 == 3'd5)));
                alt = (f7 == 7'h20);
                tag = (f3 == 3'd1 || f3 == 3'd5) ? "R2" :
                      (f3 == 3'd2 || f3 == 3'd3) ? "R3" : "R1";
            end else begin
                y   = immi;
                alt = (f3 == 3'd5) && (f7 == 7'h20);
                ill = (f3 == 3'd1) ? (f7 != 7'h00) :
                      (f3 == 3'd5) ? !(f7 == 7'h00 || f7 == 7'h20) : 1'b0;
                tag = (f3 == 3'd1 || f3 == 3'd5) ? "R6" : (f3 == 3'd3) ? "R5" :
                      (f3 == 3'd2) ? "R3" : "R4";
            end
            case (f3)
                3'd0: r = alt ? a - y : a + y;
                3'd1: r = a << (y % 32);
                3'd2: r = ($signed(a) < $signed(y)) ? 32'd1 : 32'd0;
                3'd3: r = (a < y) ? 32'd1 : 32'd0;
                3'd4: r = a ^ y;
                3'd5: r = alt ? 32'($signed(a) >>> (y % 32)) : a >> (y % 32);
                3'd6: r = a | y;
                default: r = a & y;
            endcase
        end else if (opc == 7'b0110111) begin
            ill = 1'b0; r = immu; tag = "R7";
        end else if (opc == 7'b0010111) begin
            ill = 1'b0; r = p + immu; tag = "R8";
        end
        if (ill) begin
            r = 32'h0; tag = "R9";
        end
        we = !ill && (ins[11:7] != 5'd0);
    endfunction

    task automatic run(input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] p, input string force_tag);
        logic [31:0] er;
        logic        ewe;
        logic        eill;
        string       tag;
        @(posedge clk);
        #1;
        instr = ins; rs1 = a; rs2 = b; pc = p;
        model(ins, a, b, p, er, ewe, eill, tag);
        if (force_tag != "") tag = force_tag;
        @(negedge clk);
        n_cmp++;
        if (result !== er || wr_en !== ewe || illegal !== eill) begin
            n_bad++;
            $display("FAIL %s instr=%h a=%h b=%h pc=%h: got res=%h we=%b ill=%b, expected res=%h we=%b ill=%b",
                     tag, ins, a, b, p, result, wr_en, illegal, er, ewe, eill);
        end
    endtask

    function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, 5'd2, 5'd1, f3, rd, 7'b0110011};
    endfunction

    initial begin
        // Reset-time state: all-zero word is an unsupported opcode (R9)
        run(32'h0, 32'h0, 32'h0, 32'h0, "R9");

        // R1 R2 R3: register-register over operand patterns and function values
        for (int f3 = 0; f3 < 8; f3++)
            foreach (pats[i])
                foreach (pats[j]) begin
                    run(rtype(7'h00, 3'(f3), 5'd5), pats[i], pats[j], 32'h0, "");
                    run(rtype(7'h20, 3'(f3), 5'd5), pats[i], pats[j], 32'h0, "");
                end
        // R9: every seven-bit function value
        for (int f3 = 0; f3 < 8; f3++)
            for (int f7 = 0; f7 < 128; f7++)
                run(rtype(7'(f7), 3'(f3), 5'd7), 32'h8000_00F0, 32'h0000_0024, 32'h0, "");

        // R4 R5 R3: immediate forms with sign-clear and sign-set immediates
        for (int f3 = 0; f3 < 8; f3++) begin
            if (f3 == 1 || f3 == 5) continue;
            foreach (pats[i])
                for (int k = 0; k < 8; k++) begin
                    logic [11:0] imm = (k == 0) ? 12'h000 : (k == 1) ? 12'h001 :
                                       (k == 2) ? 12'h7FF : (k == 3) ? 12'h800 :
                                       (k == 4) ? 12'hFFF : (k == 5) ? 12'h41F :
                                       (k == 6) ? 12'h678 : 12'hA5C;
                    run({imm, 5'd3, 3'(f3), 5'd9, 7'b0010011}, pats[i], 32'hDEAD_BEEF, 32'h0, "");
                end
        end

        // R6: immediate shifts, every amount and every upper-field value
        for (int f7 = 0; f7 < 128; f7++)
            for (int sh = 0; sh < 32; sh++) begin
                run({7'(f7), 5'(sh), 5'd3, 3'd1, 5'd4, 7'b0010011}, 32'h8000_0F0F, 32'h0, 32'h0, "");
                run({7'(f7), 5'(sh), 5'd3, 3'd5, 5'd4, 7'b0010011}, 32'h8000_0F0F, 32'h0, 32'h0, "");
            end

        // R7 R8: upper immediates over PC values
        for (int k = 0; k < 8; k++)
            foreach (pats[i]) begin
                logic [19:0] u = pats[k][31:12] ^ 20'h5A5A5;
                run({u, 5'd6, 7'b0110111}, pats[i], pats[k], pats[i], "R7");
                run({u, 5'd6, 7'b0010111}, pats[i], pats[k], pats[i], "R8");
            end

        // R9: every opcode
        for (int op = 0; op < 128; op++)
            run({7'h00, 5'd2, 5'd1, 3'd0, 5'd8, 7'(op)}, 32'h0000_1000, 32'h0000_0234, 32'h0000_4000, "");

        // R10: every destination index, for a register form and load-upper
        for (int rd = 0; rd < 32; rd++) begin
            run(rtype(7'h00, 3'd0, 5'(rd)), 32'h0000_0011, 32'h0000_0022, 32'h0, "R10");
            run({20'hABCDE, 5'(rd), 7'b0110111}, 32'h0, 32'h0, 32'h0, "R10");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule